// File: doc/BRIEF.md
# Terminal Receive Register Interface

This block is the processor-facing side of a character terminal receiver. It takes characters that a separate deserializer has already assembled. A one-cycle valid strobe delivers each character, with a flag that marks a line break condition. The block holds the character in a receive buffer, sets a done flag and, when enabled, raises a level interrupt request. The request stays asserted until software deals with it.

Software sees two word registers on a simple bus. One bus cycle carries an address, write data, a write strobe, a read strobe and a byte-access flag. Address bit 1 selects the register: 0 is the status word and 1 is the buffer. A read of the buffer has a side effect: it consumes the character. A configuration pin picks 7-bit or 8-bit characters. A free-running count of accepted characters is brought out so that a test can watch it.

Top module: `term_rx_regs`

## Requirements
- R1: Address bit 1 selects the register, with 0 for the status word and 1 for the buffer. Read data is combinational from the current state. The status word reads done at bit 7 and enable at bit 6, and every other bit reads 0. The buffer reads the stored character in bits 7:0, and bits 15:8 read 0.
- R2: A write to the status word changes only the enable bit, which takes write-data bit 6. A write to the buffer changes nothing.
- R3: A byte write (byte flag 1) to the odd byte of the status word (address bit 0 = 1) has no effect. A byte write to the even byte behaves like a word write.
- R4: Writing enable as 0 drops the interrupt request in the next cycle.
- R5: Writing enable as 1 raises the request only when done is 1 and enable was 0 before the write. Otherwise the request is left as it was.
- R6: A buffer read returns the character and clears done and the request at the following clock edge.
- R7: With the mode pin at 0, a received character is stored with bit 7 forced to 0. With the mode pin at 1, all 8 bits are stored.
- R8: A character flagged as break stores 0 in the buffer.
- R9: An accepted character sets done. It also sets the request when enable is 1 after any enable write in the same cycle.
- R10: A character that arrives before the previous one is read overwrites the buffer, and done stays 1.
- R11: The character counter increments by one on each accepted character and holds otherwise.
- R12: Reset clears the buffer, done, enable, the request and the counter.
- R13: When a character arrives in the same cycle as a buffer read, the new character wins. Done ends at 1, and the request follows enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (3) | Register byte address |
| bus_wdata | input | DATA_W (16) | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effects) |
| bus_byte | input | 1 | Byte access flag |
| bus_rdata | output | DATA_W (16) | Read data for the addressed register |
| rx_valid | input | 1 | Character delivered this cycle |
| rx_char | input | CHAR_W (8) | Incoming character |
| rx_break | input | 1 | Break condition marker |
| cfg_eight | input | 1 | 1 = 8-bit characters, 0 = 7-bit |
| irq | output | 1 | Level interrupt request |
| rx_count | output | CNT_W (16) | Accepted character count |

## Verification
The hardest state to reach is the set of collisions between the bus and arriving characters. These are a buffer read in the same cycle as a character arrival, and an enable write that lands while done is already set. Plain ordered traffic never produces either one. The directed stimulus places the character strobe on the exact cycle of a buffer read, and it turns enable on only after a character has been left unread. A long stretch of random traffic then mixes reads, word and byte writes, breaks and mode changes. A behavioural model is compared against the outputs on every cycle of it.

// File: rtl/term_rx_pkg.sv
package term_rx_pkg;

   // Strobes produced by the address decoder for one bus cycle.
   typedef struct packed {
      logic stat_wr;
      logic stat_rd;
      logic data_rd;
      logic data_wr;
   } rx_strobe_t;

   // Byte lane assignment of a register word.
   localparam int LANE_BITS = 8;

endpackage

// File: rtl/term_rx_decode.sv
module term_rx_decode
   import term_rx_pkg::*;
#(
   parameter int ADDR_W = 3
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              rd,
   input  logic              byte_acc,
   output logic              sel_data,
   output rx_strobe_t        strb
);

   localparam int SEL_BIT = 1;
   localparam int ODD_BIT = 0;

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("term_rx_decode: ADDR_W must be at least 2");
      end
   endgenerate

   logic odd_lane;

   always_comb begin
      sel_data = addr[SEL_BIT];
      odd_lane = byte_acc & addr[ODD_BIT];
      strb.stat_wr = wr & ~sel_data & ~odd_lane;
      strb.stat_rd = rd & ~sel_data;
      strb.data_rd = rd &  sel_data;
      strb.data_wr = wr &  sel_data;
   end

endmodule

// File: rtl/term_rx_charpath.sv
module term_rx_charpath #(
   parameter int CHAR_W = 8,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [CHAR_W-1:0] char_in,
   input  logic              brk,
   input  logic              wide,
   output logic [CHAR_W-1:0] buf_q,
   output logic [CNT_W-1:0]  cnt_q
);

   localparam int NARROW_W = CHAR_W - 1;
   localparam logic [CHAR_W-1:0] NARROW_MASK = {1'b0, {NARROW_W{1'b1}}};

   generate
      if (CHAR_W < 2) begin : g_bad_char
         $error("term_rx_charpath: CHAR_W must be at least 2");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("term_rx_charpath: CNT_W must be positive");
      end
   endgenerate

   logic [CHAR_W-1:0] masked;

   always_comb begin
      if (brk)
         masked = '0;
      else if (wide)
         masked = char_in;
      else
         masked = char_in & NARROW_MASK;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         buf_q <= '0;
         cnt_q <= '0;
      end else if (take) begin
         buf_q <= masked;
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

endmodule

// File: rtl/term_rx_status.sv
module term_rx_status
   import term_rx_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int IE_POS = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  rx_strobe_t        strb,
   input  logic [DATA_W-1:0] wdata,
   input  logic              take,
   output logic              done_q,
   output logic              ie_q,
   output logic              irq_q
);

   generate
      if (IE_POS >= DATA_W) begin : g_bad_ie
         $error("term_rx_status: IE_POS outside the word");
      end
   endgenerate

   logic done_d, ie_d, irq_d, wr_bit;

   always_comb begin
      wr_bit = wdata[IE_POS];
      done_d = done_q;
      ie_d   = ie_q;
      irq_d  = irq_q;
      if (strb.stat_wr) begin
         ie_d = wr_bit;
         if (!wr_bit)
            irq_d = 1'b0;
         else if (done_q && !ie_q)
            irq_d = 1'b1;
      end
      if (strb.data_rd) begin
         done_d = 1'b0;
         irq_d  = 1'b0;
      end
      if (take) begin
         done_d = 1'b1;
         if (ie_d)
            irq_d = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         ie_q   <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         done_q <= done_d;
         ie_q   <= ie_d;
         irq_q  <= irq_d;
      end
   end

endmodule

// File: rtl/term_rx_regs.sv
module term_rx_regs
   import term_rx_pkg::*;
#(
   parameter int ADDR_W   = 3,
   parameter int DATA_W   = 16,
   parameter int CHAR_W   = 8,
   parameter int CNT_W    = 16,
   parameter int DONE_POS = 7,
   parameter int IE_POS   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic              bus_byte,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              rx_valid,
   input  logic [CHAR_W-1:0] rx_char,
   input  logic              rx_break,
   input  logic              cfg_eight,
   output logic              irq,
   output logic [CNT_W-1:0]  rx_count
);

   localparam int PAD_W = DATA_W - CHAR_W;

   generate
      if (DATA_W < CHAR_W) begin : g_bad_width
         $error("term_rx_regs: DATA_W must hold a character");
      end
      if (DONE_POS == IE_POS || DONE_POS >= DATA_W) begin : g_bad_pos
         $error("term_rx_regs: status bit positions invalid");
      end
      if (DATA_W != 2 * LANE_BITS) begin : g_bad_lanes
         $error("term_rx_regs: word must be two byte lanes");
      end
   endgenerate

   rx_strobe_t        strb;
   logic              sel_data;
   logic              done_q, ie_q, irq_q;
   logic [CHAR_W-1:0] buf_q;
   logic [DATA_W-1:0] stat_word, data_word;

   term_rx_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr     (bus_addr),
      .wr       (bus_wr),
      .rd       (bus_rd),
      .byte_acc (bus_byte),
      .sel_data (sel_data),
      .strb     (strb)
   );

   term_rx_charpath #(.CHAR_W(CHAR_W), .CNT_W(CNT_W)) u_path (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (rx_valid),
      .char_in (rx_char),
      .brk     (rx_break),
      .wide    (cfg_eight),
      .buf_q   (buf_q),
      .cnt_q   (rx_count)
   );

   term_rx_status #(.DATA_W(DATA_W), .IE_POS(IE_POS)) u_stat (
      .clk    (clk),
      .rst_n  (rst_n),
      .strb   (strb),
      .wdata  (bus_wdata),
      .take   (rx_valid),
      .done_q (done_q),
      .ie_q   (ie_q),
      .irq_q  (irq_q)
   );

   always_comb begin
      stat_word           = '0;
      stat_word[DONE_POS] = done_q;
      stat_word[IE_POS]   = ie_q;
   end

   generate
      if (PAD_W > 0) begin : g_pad
         assign data_word = {{PAD_W{1'b0}}, buf_q};
      end else begin : g_nopad
         assign data_word = buf_q;
      end
   endgenerate

   assign bus_rdata = sel_data ? data_word : stat_word;
   assign irq       = irq_q;

endmodule

// File: rtl/term_rx_regs_chk.sv
module term_rx_regs_chk #(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 16,
   parameter int CHAR_W = 8,
   parameter int CNT_W  = 16,
   parameter int IE_POS = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic              bus_byte,
   input logic              rx_valid,
   input logic              rx_break,
   input logic              irq,
   input logic              done_q,
   input logic              ie_q,
   input logic [CHAR_W-1:0] buf_q,
   input logic [CNT_W-1:0]  rx_count
);

   logic stat_wr_c;
   assign stat_wr_c = bus_wr && !bus_addr[1] && !(bus_byte && bus_addr[0]);

   // R9: a request never stands without a pending character
   p_irq_needs_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> done_q);

   // R6: a buffer read with no new character clears the request
   p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr[1] && !rx_valid) |=> (!irq && !done_q));

   // R4: writing enable as 0 drops the request
   p_ie_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr_c && !bus_wdata[IE_POS]) |=> !irq);

   // R11: counter steps on each character
   p_cnt_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> (rx_count == $past(rx_count) + CNT_W'(1)));

   // R11: counter holds without a character
   p_cnt_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |=> $stable(rx_count));

   // R2: the buffer only changes on an arriving character
   p_buf_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |=> $stable(buf_q));

   // R8: break stores zero
   p_break_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_break) |=> (buf_q == '0));

   // R5: a request rises only from a character or an enable turn-on
   p_irq_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq && !rx_valid && !(stat_wr_c && bus_wdata[IE_POS] && !ie_q)) |=> !irq);

   // R3: odd byte writes leave enable alone
   p_odd_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_byte && bus_addr[0] && !bus_addr[1]) |=> $stable(ie_q));

endmodule

bind term_rx_regs term_rx_regs_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAR_W(CHAR_W), .CNT_W(CNT_W), .IE_POS(IE_POS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_byte  (bus_byte),
   .rx_valid  (rx_valid),
   .rx_break  (rx_break),
   .irq       (irq),
   .done_q    (done_q),
   .ie_q      (ie_q),
   .buf_q     (buf_q),
   .rx_count  (rx_count)
);

// File: tb/term_rx_regs_bench.sv
module term_rx_regs_bench;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [2:0]  bus_addr;
   logic [15:0] bus_wdata;
   logic        bus_wr, bus_rd, bus_byte;
   logic [15:0] bus_rdata;
   logic        rx_valid;
   logic [7:0]  rx_char;
   logic        rx_break, cfg_eight;
   logic        irq;
   logic [15:0] rx_count;

   term_rx_regs u_term_rx_regs (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_byte(bus_byte), .bus_rdata(bus_rdata),
      .rx_valid(rx_valid), .rx_char(rx_char), .rx_break(rx_break),
      .cfg_eight(cfg_eight), .irq(irq), .rx_count(rx_count)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_vec = 0;
   int n_bad = 0;
   string cur_req = "R12";

   // reference model state
   bit      m_done, m_ie, m_irq;
   int      m_buf, m_cnt;

   task automatic chk(string tag, int got, int exp);
      n_vec++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
      end
   endtask

   function automatic int model_rdata();
      if (bus_addr[1]) return m_buf;
      return (int'(m_done) << 7) | (int'(m_ie) << 6);
   endfunction

   task automatic model_reset();
      m_done = 0; m_ie = 0; m_irq = 0; m_buf = 0; m_cnt = 0;
   endtask

   task automatic model_step();
      bit stat_write;
      bit newie;
      stat_write = bus_wr && !bus_addr[1] && !(bus_byte && bus_addr[0]);
      if (stat_write) begin
         newie = bus_wdata[6];
         if (!newie) m_irq = 0;
         else if (m_done && !m_ie) m_irq = 1;
         m_ie = newie;
      end
      if (bus_rd && bus_addr[1]) begin
         m_done = 0; m_irq = 0;
      end
      if (rx_valid) begin
         if (rx_break) m_buf = 0;
         else if (cfg_eight) m_buf = rx_char;
         else m_buf = rx_char & 8'h7F;
         m_done = 1;
         if (m_ie) m_irq = 1;
         m_cnt = (m_cnt + 1) & 16'hFFFF;
      end
   endtask

   // One clock: inputs are already set; compare outputs mid-cycle, then advance.
   task automatic cycle();
      #1;
      chk({cur_req, " rdata"}, bus_rdata, model_rdata());
      chk({cur_req, " irq"}, irq, m_irq);
      chk({"R11 count (", cur_req, ")"}, rx_count, m_cnt);
      @(posedge clk);
      if (!rst_n) model_reset(); else model_step();
      @(negedge clk);
      bus_wr = 0; bus_rd = 0; bus_byte = 0; rx_valid = 0; rx_break = 0;
   endtask

   task automatic idle(input logic [2:0] a);
      bus_addr = a; cycle();
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d, input bit bt);
      bus_addr = a; bus_wdata = d; bus_wr = 1; bus_byte = bt; cycle();
   endtask

   task automatic rd(input logic [2:0] a);
      bus_addr = a; bus_rd = 1; cycle();
   endtask

   task automatic rx(input logic [7:0] c, input bit brk);
      rx_char = c; rx_break = brk; rx_valid = 1; cycle();
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      rst_n = 0; bus_addr = 0; bus_wdata = 0; bus_wr = 0; bus_rd = 0; bus_byte = 0;
      rx_valid = 0; rx_char = 0; rx_break = 0; cfg_eight = 0;
      model_reset();
      @(negedge clk);
      cycle(); cycle();
      rst_n = 1;
      // R12: state after reset
      cur_req = "R12"; idle(3'd0); idle(3'd2);
      chk("R12 irq after reset", irq, 0);
      // R7 / R9: 7-bit character, enable off
      cur_req = "R7"; rx(8'hC1, 0);
      cur_req = "R9"; idle(3'd2);
      chk("R7 masked char", bus_rdata, 16'h0041);
      idle(3'd0);
      chk("R9 done no irq", {bus_rdata, 15'd0, irq}, {16'h0080, 16'h0000});
      // R5 / R2: enable on while done set, other bits ignored
      cur_req = "R5"; wr(3'd0, 16'hFFBF, 0); wr(3'd0, 16'hFFFF, 0);
      idle(3'd0);
      chk("R2 status bits", bus_rdata, 16'h00C0);
      chk("R5 irq on enable turn-on", irq, 1);
      // R6: buffer read clears
      cur_req = "R6"; rd(3'd2); idle(3'd0);
      chk("R6 done cleared", bus_rdata, 16'h0040);
      chk("R6 irq cleared", irq, 0);
      // R5: enable already on, done clear: no request
      cur_req = "R5"; wr(3'd0, 16'h0040, 0); idle(3'd0);
      chk("R5 no irq without done", irq, 0);
      // R9: char with enable on
      cur_req = "R9"; rx(8'h33, 0); idle(3'd0);
      chk("R9 irq on char", irq, 1);
      // R4: enable off drops request
      cur_req = "R4"; wr(3'd0, 16'h0000, 0); idle(3'd0);
      chk("R4 irq dropped", irq, 0);
      chk("R4 done kept", bus_rdata, 16'h0080);
      // R3: odd byte write ignored, even byte write honoured
      cur_req = "R3"; wr(3'd1, 16'h4040, 1); idle(3'd0);
      chk("R3 odd byte ignored", bus_rdata, 16'h0080);
      wr(3'd0, 16'h0040, 1); idle(3'd0);
      chk("R3 even byte taken", bus_rdata, 16'h00C0);
      // R2: buffer write ignored
      cur_req = "R2"; wr(3'd2, 16'h00FF, 0); idle(3'd2);
      chk("R2 buffer write ignored", bus_rdata, 16'h0033);
      // R7: 8-bit mode
      cur_req = "R7"; cfg_eight = 1; rx(8'hC1, 0); idle(3'd2);
      chk("R7 eight bit char", bus_rdata, 16'h00C1);
      // R8: break
      cur_req = "R8"; rx(8'h7E, 1); idle(3'd2);
      chk("R8 break stores zero", bus_rdata, 0);
      // R10: overrun
      cur_req = "R10"; rx(8'h11, 0); rx(8'h22, 0); idle(3'd2);
      chk("R10 overwrite", bus_rdata, 16'h0022);
      idle(3'd0);
      chk("R10 done stays", bus_rdata[7], 1);
      // R13: read and char in the same cycle
      cur_req = "R13"; bus_rd = 1; bus_addr = 3'd2; rx_char = 8'h5A; rx_valid = 1; cycle();
      idle(3'd0);
      chk("R13 done set", bus_rdata[7], 1);
      chk("R13 irq follows enable", irq, 1);
      idle(3'd2);
      chk("R13 new char", bus_rdata, 16'h005A);
      // R1: mixed random traffic compared every cycle
      cur_req = "R1";
      for (int i = 0; i < 3000; i++) begin
         bus_addr  = 3'($urandom_range(0, 7));
         bus_wdata = 16'($urandom);
         bus_byte  = 1'($urandom);
         case ($urandom_range(0, 3))
            0: bus_wr = 1;
            1: bus_rd = 1;
            default: ;
         endcase
         rx_valid  = ($urandom_range(0, 3) == 0);
         rx_char   = 8'($urandom);
         rx_break  = ($urandom_range(0, 7) == 0);
         if ((i % 200) == 0) cfg_eight = 1'($urandom);
         cycle();
      end
      // R12: reset mid-run
      cur_req = "R12"; rst_n = 0; cycle(); rst_n = 1;
      idle(3'd0); idle(3'd2);
      chk("R12 counter cleared", rx_count, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule